// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a processor virtual address into a physical address. It reads one translation entry from a table held in memory. A request carries the virtual address and two attribute flags: whether the access is a write, and whether it comes from user mode. The request is taken through a valid/ready handshake. The walker then adds twice the virtual page number to a table base register to form the address of the 16-bit entry, and fetches that entry through a single-beat memory read port whose latency is not fixed. From the entry it either builds the physical address or reports why the access must trap.

The walker handles one translation at a time. It keeps nothing from a walk once that walk has reported. Software can therefore rewrite an entry after a fault and present the same address again, and the new entry is used. The table base is written through a load strobe. The strobe takes effect only while no walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 while `mem_req`, `rsp_done` and `rsp_fault` are 0.
- R2: For each accepted request, the entry is fetched from `mem_addr` = table base + 2 × VPN, where the VPN is `req_va[15:8]`. The base is taken as it stands in the cycle the request is accepted.
- R3: If the entry allows the access, `rsp_pa` = {entry[5:0], `req_va[7:0]`}. The page offset is carried through unchanged, and `rsp_fault` = 2'b00.
- R4: If entry bit 15 (present) is 0, `rsp_fault` = 2'b01 (not present).
- R5: Whenever `rsp_fault` is not 2'b00, `rsp_pa` is 0.
- R6: A present entry gives `rsp_fault` = 2'b10 (protection) in three cases: a user access to an entry with bit 14 (supervisor-only) set; a write to an entry with bit 12 (writable) clear; a read from an entry with bit 13 (readable) clear. A supervisor access to a supervisor-only page is allowed.
- R7: A non-present entry reports 2'b01 even when its permission bits would also fail. The code 2'b11 never appears.
- R8: After a fault, the same virtual address can be presented again once the entry in memory has been rewritten, and it then translates from the new entry.
- R9: A `base_ld` pulse in a cycle where `req_ready` is 1 replaces the table base with `base_val`. A pulse during a walk is ignored, and the following walks use the previous base.
- R10: Only one walk is outstanding. `mem_req` is a one-cycle pulse per accepted request, and `req_ready` stays 0 from acceptance until the result is reported.
- R11: `rsp_done` pulses for exactly one cycle, in the cycle after `mem_rvalid` is seen, for any read latency of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_ld | input | 1 | Table base load strobe |
| base_val | input | 16 | New table base value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 16 | Virtual address |
| req_write | input | 1 | Access is a write (1) or a read (0) |
| req_user | input | 1 | Access comes from user mode |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 16 | Entry byte address |
| mem_rvalid | input | 1 | Entry read data valid |
| mem_rdata | input | 16 | Entry read data |
| rsp_done | output | 1 | Result valid pulse |
| rsp_pa | output | 14 | Physical address |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |

## Verification
Entries are built to be present and fully permitted, to be absent with all permission bits clear, or to be present with exactly one permission missing. Each of these cases tells the correct fault code apart from a wrong check or a wrong priority. User and supervisor requests to the same supervisor-only page separate the mode check from the read and write checks. The highest VPN together with a nonzero offset exposes errors in address slicing and in the base addition. Read latencies from one to four cycles, a base load issued in the middle of a walk, and a retry after the entry is rewritten separate correct sequencing from stale state and from loads being accepted while busy.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } state_e;

  localparam int BIT_PRESENT = 15;
  localparam int BIT_SUPER   = 14;
  localparam int BIT_READ    = 13;
  localparam int BIT_WRITE   = 12;
endpackage

// File: rtl/pt_fsm.sv
module pt_fsm
  import pt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic req_valid,
  input  logic mem_rvalid,
  output logic req_ready,
  output logic accept,
  output logic mem_req,
  output logic capture,
  output logic idle
);
  state_e st_q, st_d;

  always_comb begin
    req_ready = (st_q == ST_IDLE) && run;
    accept    = req_valid && req_ready;
    mem_req   = (st_q == ST_ISSUE);
    capture   = (st_q == ST_WAIT) && mem_rvalid;
    idle      = (st_q == ST_IDLE);
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (mem_rvalid) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int MA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [MA_W-1:0] ld_val,
  output logic [MA_W-1:0] base
);
  logic [MA_W-1:0] base_d;

  always_comb base_d = ld_en ? ld_val : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base <= '0;
    else        base <= base_d;
  end
endmodule

// File: rtl/pt_check.sv
module pt_check
  import pt_pkg::*;
#(
  parameter int PTE_W = 16,
  parameter int PPN_W = 6,
  parameter int PG_W  = 8,
  localparam int PA_W = PPN_W + PG_W
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [PG_W-1:0]  offset,
  input  logic             is_write,
  input  logic             is_user,
  output fault_e           fault,
  output logic [PA_W-1:0]  pa
);
  logic denied;

  always_comb begin
    denied = (is_user && pte[BIT_SUPER])
           || (is_write && !pte[BIT_WRITE])
           || (!is_write && !pte[BIT_READ]);
    if (!pte[BIT_PRESENT]) fault = FLT_ABSENT;
    else if (denied)       fault = FLT_PROT;
    else                   fault = FLT_NONE;
    pa = (fault == FLT_NONE) ? {pte[PPN_W-1:0], offset} : '0;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int PA_W  = 14,
  parameter int PG_W  = 8,
  parameter int PTE_W = 16,
  parameter int MA_W  = 16,
  localparam int VPN_W = VA_W - PG_W,
  localparam int PPN_W = PA_W - PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_ld,
  input  logic [MA_W-1:0]  base_val,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_done,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_fault
);
  // reset: asserted asynchronously, released on the clock
  logic rs_meta, rs_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  logic accept, capture, idle;
  logic [MA_W-1:0] base;

  pt_fsm u_fsm (
    .clk(clk), .rst_n(rs_sync), .run(rs_sync),
    .req_valid(req_valid), .mem_rvalid(mem_rvalid),
    .req_ready(req_ready), .accept(accept), .mem_req(mem_req),
    .capture(capture), .idle(idle)
  );

  pt_base_reg #(.MA_W(MA_W)) u_base (
    .clk(clk), .rst_n(rs_sync),
    .ld_en(base_ld && idle && rs_sync),
    .ld_val(base_val), .base(base)
  );

  // request capture
  logic [MA_W-1:0] addr_q, addr_d;
  logic [PG_W-1:0] off_q;
  logic            wr_q, usr_q;

  always_comb
    addr_d = base + {{(MA_W-VPN_W-1){1'b0}}, req_va[VA_W-1:PG_W], 1'b0};

  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) begin
      addr_q <= '0;
      off_q  <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= addr_d;
      off_q  <= req_va[PG_W-1:0];
      wr_q   <= req_write;
      usr_q  <= req_user;
    end
  end

  assign mem_addr = addr_q;

  // entry check
  fault_e          chk_fault;
  logic [PA_W-1:0] chk_pa;

  pt_check #(.PTE_W(PTE_W), .PPN_W(PPN_W), .PG_W(PG_W)) u_check (
    .pte(mem_rdata), .offset(off_q), .is_write(wr_q), .is_user(usr_q),
    .fault(chk_fault), .pa(chk_pa)
  );

  // result registers
  logic            done_q;
  logic [PA_W-1:0] pa_q;
  fault_e          fault_q;

  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) done_q <= 1'b0;
    else          done_q <= capture;
  end

  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) begin
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else if (capture) begin
      pa_q    <= chk_pa;
      fault_q <= chk_fault;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_pa    = pa_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W = 16,
  parameter int PA_W = 14,
  parameter int PG_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            mem_req,
  input logic            mem_rvalid,
  input logic            rsp_done,
  input logic [PA_W-1:0] rsp_pa,
  input logic [1:0]      rsp_fault
);
  logic [VA_W-1:0] va_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) va_seen <= '0;
    else if (req_valid && req_ready) va_seen <= req_va;
  end

  assert_single_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
  assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && !req_ready && !mem_req) |=> rsp_done);
  assert_done_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(mem_rvalid));
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault == 2'b00) |-> rsp_pa[PG_W-1:0] == va_seen[PG_W-1:0]);
  assert_fault_pa_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault != 2'b00) |-> rsp_pa == '0);
  assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_fault != 2'b11);
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .rsp_done(rsp_done), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_ld = 1'b0;
  logic [15:0] base_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        rsp_done;
  logic [13:0] rsp_pa;
  logic [1:0]  rsp_fault;

  always #4 clk = ~clk;

  pt_walker u0 (.*);

  localparam logic [15:0] P = 16'h8000, S = 16'h4000, RD = 16'h2000, WR = 16'h1000;

  int checks = 0, failures = 0, done_seen = 0, lat = 1;
  logic [15:0] tb_base = '0;
  logic [15:0] exp_addr = '0;
  logic [15:0] tbl [0:1023];
  logic [15:0] exp_q[$];   // {fault, pa}
  string       tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_pte(input logic [7:0] vpn, input logic [15:0] v);
    logic [15:0] a;
    a = tb_base + {7'd0, vpn, 1'b0};
    tbl[a[10:1]] = v;
  endtask

  task automatic load_base(input logic [15:0] v);
    @(negedge clk);
    base_ld = 1'b1; base_val = v;
    @(negedge clk);
    base_ld = 1'b0;
    tb_base = v;   // R9: idle load takes effect
  endtask

  task automatic walk(input logic [15:0] va, input bit wr, input bit usr, input string req,
                      input bit mid_ld);
    logic [15:0] a, pte;
    logic [1:0]  f;
    logic [13:0] pa;
    int          start;
    a   = tb_base + {7'd0, va[15:8], 1'b0};
    pte = tbl[a[10:1]];
    if (!pte[15]) f = 2'b01;
    else if ((usr && pte[14]) || (wr && !pte[12]) || (!wr && !pte[13])) f = 2'b10;
    else f = 2'b00;
    pa = (f == 2'b00) ? {pte[5:0], va[7:0]} : 14'd0;
    exp_q.push_back({f, pa});
    tag_q.push_back(req);
    exp_addr = a;
    start = done_seen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
    if (mid_ld) begin
      base_ld = 1'b1; base_val = 16'h0200;   // R9: ignored while busy
      @(negedge clk);
      base_ld = 1'b0;
    end
    while (done_seen == start) @(negedge clk);
  endtask

  // memory model; every fetch address is checked (R2)
  always begin
    @(negedge clk);
    if (mem_req) begin
      chk(mem_addr == exp_addr, "R2 entry address", mem_addr, exp_addr);
      repeat (lat) @(negedge clk);
      mem_rvalid = 1'b1;
      mem_rdata  = tbl[mem_addr[10:1]];
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_rdata  = '0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rsp_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 1, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_fault == e[15:14], {t, " fault"}, rsp_fault, e[15:14]);
        chk(rsp_pa == e[13:0], {t, " pa"}, rsp_pa, e[13:0]);
      end
      done_seen++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(mem_req == 1'b0 && rsp_done == 1'b0 && rsp_fault == 2'b00, "R1 outputs idle",
        {mem_req, rsp_done, rsp_fault}, 0);

    load_base(16'h0100);
    set_pte(8'h03, P | RD | WR | 16'h002A);
    set_pte(8'h10, P | RD | 16'h0005);
    set_pte(8'h20, P | S | RD | WR | 16'h0011);
    set_pte(8'h30, 16'h0000);
    set_pte(8'h31, P | WR | 16'h0007);
    set_pte(8'hFF, P | RD | WR | 16'h003F);
    set_pte(8'h41, S);

    lat = 1; walk(16'h03C5, 1'b1, 1'b1, "R3 user write ok", 1'b0);
    lat = 3; walk(16'h1077, 1'b0, 1'b1, "R3 read-only read", 1'b0);
    lat = 2; walk(16'h1000, 1'b1, 1'b0, "R6 write no W", 1'b0);
    lat = 4; walk(16'h2012, 1'b0, 1'b1, "R6 user on super", 1'b0);
    lat = 1; walk(16'h2012, 1'b1, 1'b0, "R6 super on super", 1'b0);
    lat = 2; walk(16'h3180, 1'b0, 1'b0, "R6 read no R", 1'b0);
    lat = 2; walk(16'h3180, 1'b1, 1'b0, "R6 write-only write", 1'b0);
    lat = 3; walk(16'hFFFF, 1'b0, 1'b1, "R3 top page", 1'b0);
    lat = 1; walk(16'h4101, 1'b1, 1'b1, "R7 absent beats prot", 1'b0);
    lat = 2; walk(16'h3055, 1'b0, 1'b0, "R4 not present", 1'b0);
    set_pte(8'h30, P | RD | WR | 16'h0012);
    lat = 1; walk(16'h3055, 1'b0, 1'b0, "R8 retry after update", 1'b0);
    lat = 3; walk(16'h0301, 1'b0, 1'b0, "R9 busy load walk", 1'b1);
    lat = 1; walk(16'h1002, 1'b0, 1'b0, "R9 old base kept", 1'b0);
    load_base(16'h0300);
    set_pte(8'h03, P | RD | 16'h0001);
    lat = 2; walk(16'h03AB, 1'b0, 1'b1, "R9 idle load used", 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule